// File: doc/BRIEF.md
# Q1.15 Fixed-Point Multiply and Extract Unit

This block takes two signed fixed-point operands with one integer bit and fifteen fraction bits, each standing for the integer value divided by 2^15, so each covers -1 up to 1 - 2^-15. It forms the exact 32-bit product, which is a 2.30 number. It keeps that product in a double-width accumulator stage, then narrows it back to a 1.15 word that a data register can hold.

Narrowing keeps the 16 bits just below the product's top bit, so the binary point stays where it was. The low fraction bits are either dropped or rounded to the nearest value first, as the caller chooses per operation. The only product that does not fit is -1 times -1. The unit flags it and, on request, clamps the result to the largest positive value.

Operands enter through a valid/ready handshake. Results leave two accepted cycles later with their own valid/ready pair, and a stalled output holds the whole pipeline.

Top module: `qmx_mul_extract`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both pipeline stages: out_valid, out_data and out_ovf read 0 afterwards.
- R2: With out_ready held high, an operand pair accepted at a rising edge (in_valid and in_ready both high) appears on the outputs with out_valid high after the second following rising edge.
- R3: For every operand pair other than op_a = op_b = 0x8000, out_ovf is 0 in both narrowing modes and with or without clamping.
- R4: With round_en = 0 (truncate), out_data equals bits [30:15] of the signed product, which is the product shifted right arithmetically by 15 (rounding toward minus infinity, e.g. 0xFFFF times 0x0001 gives 0xFFFF).
- R5: With round_en = 1 (round to nearest), 2^14 is added to the 32-bit product before bits [30:15] are taken (e.g. 0x0003 times 0x2000 gives 0x0001, and 0xFFFF times 0x0001 gives 0x0000).
- R6: For op_a = op_b = 0x8000 with sat_en = 0, out_ovf is 1 and out_data is the wrapped value 0x8000, in either narrowing mode.
- R7: For op_a = op_b = 0x8000 with sat_en = 1, out_ovf is 1 and out_data is 0x7FFF. Whenever out_ovf is 1, out_data is 0x7FFF or 0x8000.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid, out_data and out_ovf hold their values. An operand offered during the stall is taken once out_ready returns.
- R9: sat_en = 1 has no effect on a result without overflow: out_data matches the sat_en = 0 result for the same operands and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair this cycle |
| op_a | input | 16 | First operand, 1.15 two's complement |
| op_b | input | 16 | Second operand, 1.15 two's complement |
| round_en | input | 1 | 1 = round to nearest, 0 = truncate |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Narrowed 1.15 result |
| out_ovf | output | 1 | Result could not represent the product |

## Verification
The bench builds the unit with its default data width of 16. At that width every corner operand (0x8000, 0x8001, 0x7FFF, 0x0000, ±1 LSB) and its product fit exactly in a 64-bit integer reference. Every pairing of those corners is run under all four combinations of rounding and clamping. Random pairs then cover the rest, so the single overflow pair, the floor-versus-nearest difference on negative products and the clamp all fall inside the checked space.

// File: rtl/qmx_pkg.sv
package qmx_pkg;

  typedef enum logic {
    NARROW_TRUNC   = 1'b0,
    NARROW_NEAREST = 1'b1
  } narrow_mode_e;

  typedef enum logic {
    OVF_WRAP  = 1'b0,
    OVF_CLAMP = 1'b1
  } ovf_policy_e;

endpackage

// File: rtl/qmx_product_stage.sv
module qmx_product_stage
  import qmx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic                  take,
  input  logic [DATA_W-1:0]     op_a,
  input  logic [DATA_W-1:0]     op_b,
  input  narrow_mode_e          mode_in,
  input  ovf_policy_e           policy_in,
  output logic                  acc_valid,
  output logic [2*DATA_W-1:0]   acc_prod,
  output narrow_mode_e          acc_mode,
  output ovf_policy_e           acc_policy
);

  localparam int PROD_W = 2 * DATA_W;

  // Full-precision signed product: DATA_W x DATA_W gives PROD_W bits exactly.
  function automatic logic [PROD_W-1:0] full_product(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    logic signed [PROD_W-1:0] sa;
    logic signed [PROD_W-1:0] sb;
    logic signed [PROD_W-1:0] p;
    sa = PROD_W'($signed(a));
    sb = PROD_W'($signed(b));
    p  = sa * sb;
    return p;
  endfunction

  logic [PROD_W-1:0] prod_next;
  assign prod_next = full_product(op_a, op_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid  <= 1'b0;
      acc_prod   <= '0;
      acc_mode   <= NARROW_TRUNC;
      acc_policy <= OVF_WRAP;
    end else if (adv) begin
      acc_valid <= take;
      if (take) begin
        acc_prod   <= prod_next;
        acc_mode   <= mode_in;
        acc_policy <= policy_in;
      end
    end
  end

endmodule

// File: rtl/qmx_extract_stage.sv
module qmx_extract_stage
  import qmx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic                  acc_valid,
  input  logic [2*DATA_W-1:0]   acc_prod,
  input  narrow_mode_e          acc_mode,
  input  ovf_policy_e           acc_policy,
  output logic                  ovf_event,
  output logic                  res_valid,
  output logic [DATA_W-1:0]     res_data,
  output logic                  res_ovf
);

  localparam int PROD_W  = 2 * DATA_W;
  localparam int FRAC_W  = DATA_W - 1;
  localparam int TOP_BIT = PROD_W - 1;
  localparam int KEEP_HI = PROD_W - 2;
  localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (FRAC_W - 1);
  localparam logic [DATA_W-1:0] POS_MAX  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX  = {1'b1, {(DATA_W-1){1'b0}}};

  // Optional half-LSB bias ahead of narrowing.
  function automatic logic [PROD_W-1:0] bias_product(
    input logic [PROD_W-1:0] p,
    input narrow_mode_e      m
  );
    return (m == NARROW_NEAREST) ? p + HALF_LSB : p;
  endfunction

  // Narrowed word keeps the bits just under the product's top bit.
  function automatic logic [DATA_W-1:0] keep_window(input logic [PROD_W-1:0] p);
    return p[KEEP_HI -: DATA_W];
  endfunction

  // Result fits only if the two integer bits of the 2.30 value agree.
  function automatic logic lost_sign(input logic [PROD_W-1:0] p);
    return p[TOP_BIT] ^ p[KEEP_HI];
  endfunction

  logic [PROD_W-1:0] biased;
  logic [DATA_W-1:0] window;
  logic [DATA_W-1:0] clamp_val;
  logic [DATA_W-1:0] data_next;

  assign biased    = bias_product(acc_prod, acc_mode);
  assign window    = keep_window(biased);
  assign ovf_event = acc_valid & lost_sign(biased);
  assign clamp_val = biased[TOP_BIT] ? NEG_MAX : POS_MAX;

  always_comb begin
    data_next = window;
    if (ovf_event && acc_policy == OVF_CLAMP) begin
      data_next = clamp_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ovf   <= 1'b0;
    end else if (adv) begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_data <= data_next;
        res_ovf  <= ovf_event;
      end
    end
  end

endmodule

// File: rtl/qmx_mul_extract.sv
module qmx_mul_extract
  import qmx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              round_en,
  input  logic              sat_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ovf
);

  localparam int PROD_W = 2 * DATA_W;

  logic              adv;
  logic              take;
  logic              acc_valid;
  logic [PROD_W-1:0] acc_prod;
  narrow_mode_e      acc_mode;
  ovf_policy_e       acc_policy;
  logic              ovf_event;
  narrow_mode_e      mode_in;
  ovf_policy_e       policy_in;

  // Whole pipeline moves together; a held result stalls both stages.
  assign adv       = ~out_valid | out_ready;
  assign in_ready  = adv;
  assign take      = in_valid & in_ready;
  assign mode_in   = round_en ? NARROW_NEAREST : NARROW_TRUNC;
  assign policy_in = sat_en ? OVF_CLAMP : OVF_WRAP;

  qmx_product_stage #(.DATA_W(DATA_W)) u_prod (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .take      (take),
    .op_a      (op_a),
    .op_b      (op_b),
    .mode_in   (mode_in),
    .policy_in (policy_in),
    .acc_valid (acc_valid),
    .acc_prod  (acc_prod),
    .acc_mode  (acc_mode),
    .acc_policy(acc_policy)
  );

  qmx_extract_stage #(.DATA_W(DATA_W)) u_ext (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .acc_valid (acc_valid),
    .acc_prod  (acc_prod),
    .acc_mode  (acc_mode),
    .acc_policy(acc_policy),
    .ovf_event (ovf_event),
    .res_valid (out_valid),
    .res_data  (out_data),
    .res_ovf   (out_ovf)
  );

endmodule

// File: rtl/qmx_mul_extract_chk.sv
module qmx_mul_extract_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ovf,
  input logic              acc_valid,
  input logic [2*DATA_W-1:0] acc_prod,
  input logic              ovf_event
);

  localparam logic [2*DATA_W-1:0] ONE_PROD = (2*DATA_W)'(1) << (2*DATA_W - 2);
  localparam logic [DATA_W-1:0]   POS_MAX  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0]   NEG_MAX  = {1'b1, {(DATA_W-1){1'b0}}};

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ovf && out_data == '0 && !acc_valid));

  // R2: an accepted pair reaches the accumulator stage one edge later
  a_r2_accept_to_acc: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> acc_valid);

  // R2: an accumulator entry moves to the output while not stalled
  a_r2_acc_to_out: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (!out_valid || out_ready)) |=> out_valid);

  // R3: any product other than +1 never reports overflow
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_prod != ONE_PROD) |-> !ovf_event);

  // R6
  a_r6_one_flags: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_prod == ONE_PROD && (!out_valid || out_ready)) |=> out_ovf);

  // R7
  a_r7_ovf_value: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |-> (out_data == POS_MAX || out_data == NEG_MAX));

  // R8
  a_r8_stall_ready: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf)));

endmodule

bind qmx_mul_extract qmx_mul_extract_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_ovf   (out_ovf),
  .acc_valid (acc_valid),
  .acc_prod  (acc_prod),
  .ovf_event (ovf_event)
);

// File: tb/qmx_mul_extract_test.sv
module qmx_mul_extract_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_VEC      = 12;
  localparam int N_RAND     = 300;

  // {op_a, op_b, round_en, sat_en, expected data, expected ovf}
  localparam logic [50:0] VECS [N_VEC] = '{
    {16'h4000, 16'h4000, 1'b0, 1'b0, 16'h2000, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 1'b0, 16'h8000, 1'b1},
    {16'h8000, 16'h8000, 1'b1, 1'b0, 16'h8000, 1'b1},
    {16'h8000, 16'h8000, 1'b1, 1'b1, 16'h7FFF, 1'b1},
    {16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 16'h7FFE, 1'b0},
    {16'h7FFF, 16'h7FFF, 1'b1, 1'b0, 16'h7FFE, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0, 1'b0, 16'hFFFF, 1'b0},
    {16'hFFFF, 16'h0001, 1'b1, 1'b0, 16'h0000, 1'b0},
    {16'h8000, 16'h7FFF, 1'b1, 1'b0, 16'h8001, 1'b0},
    {16'h8001, 16'h8001, 1'b0, 1'b1, 16'h7FFE, 1'b0},
    {16'h0003, 16'h2000, 1'b0, 1'b0, 16'h0000, 1'b0},
    {16'h0003, 16'h2000, 1'b1, 1'b1, 16'h0001, 1'b0}
  };

  localparam logic [15:0] CORNERS [8] = '{
    16'h8000, 16'h8001, 16'h7FFF, 16'h0000, 16'h0001, 16'hFFFF, 16'h4000, 16'hC000
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        round_en = 1'b0;
  logic        sat_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qmx_mul_extract uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .round_en(round_en), .sat_en(sat_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
  );

  // Reference: exact integer product, then floor division by 2^15.
  function automatic void ref_model(input logic [15:0] a, input logic [15:0] b,
                                    input logic r, input logic s,
                                    output logic [15:0] d, output logic v);
    longint p;
    longint q;
    p = longint'($signed(a)) * longint'($signed(b));
    if (r) p = p + 64'sd16384;
    q = p >>> 15;
    v = (q > 64'sd32767) || (q < -64'sd32768);
    if (v && s) d = (q > 0) ? 16'h7FFF : 16'h8000;
    else        d = q[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One operation with out_ready high; result sampled at the negedge after the second edge.
  task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                        input logic r, input logic s,
                        output logic [15:0] d, output logic v, output logic ok_valid);
    @(negedge clk);
    op_a = a; op_b = b; round_en = r; sat_en = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    ok_valid = out_valid;
    d = out_data;
    v = out_ovf;
  endtask

  task automatic op_and_check(input string req, input logic [15:0] a, input logic [15:0] b,
                              input logic r, input logic s);
    logic [15:0] d, ed;
    logic v, ev, ov;
    ref_model(a, b, r, s, ed, ev);
    run_op(a, b, r, s, d, v, ov);
    check({req, " valid"}, {31'd0, ov}, 32'd1);
    check({req, " data"}, {16'd0, d}, {16'd0, ed});
    check({req, " ovf"}, {31'd0, v}, {31'd0, ev});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d, d2;
    logic v, v2, ov;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 out_data", {16'd0, out_data}, 32'd0);
    check("R1 out_ovf", {31'd0, out_ovf}, 32'd0);

    // R2: timing, valid must not appear after only one edge
    @(negedge clk);
    op_a = 16'h4000; op_b = 16'h2000; round_en = 1'b0; sat_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 not yet valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R2 valid after two edges", {31'd0, out_valid}, 32'd1);
    check("R2 data", {16'd0, out_data}, 32'h1000);

    // Vector table: R4 R5 R6 R7 R9 directed values
    for (int i = 0; i < N_VEC; i++) begin
      run_op(VECS[i][50:35], VECS[i][34:19], VECS[i][18], VECS[i][17], d, v, ov);
      check($sformatf("R4/R5/R6/R7 vec%0d valid", i), {31'd0, ov}, 32'd1);
      check($sformatf("R4/R5/R6/R7 vec%0d data", i), {16'd0, d}, {16'd0, VECS[i][16:1]});
      check($sformatf("R3/R6 vec%0d ovf", i), {31'd0, v}, {31'd0, VECS[i][0]});
    end

    // Corner sweep in all four mode combinations (R3 R4 R5 R6 R7)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 4; m++)
          op_and_check("R3 corner", CORNERS[i], CORNERS[j], m[0], m[1]);

    // R9: clamp has no effect without overflow
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if (a == 16'h8000 && b == 16'h8000) b = 16'h8001;
      run_op(a, b, k[0], 1'b0, d, v, ov);
      run_op(a, b, k[0], 1'b1, d2, v2, ov);
      check("R9 clamp no effect", {16'd0, d2}, {16'd0, d});
    end

    // Random pairs (R3 R4 R5)
    for (int k = 0; k < N_RAND; k++)
      op_and_check("R4/R5 random", 16'($urandom), 16'($urandom), k[0], k[1]);

    // R8: backpressure
    @(negedge clk);
    out_ready = 1'b0;
    op_a = 16'h2000; op_b = 16'h2000; round_en = 1'b0; sat_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    op_a = 16'hC000; op_b = 16'h4000;
    @(negedge clk);
    check("R8 first result held valid", {31'd0, out_valid}, 32'd1);
    check("R8 first data", {16'd0, out_data}, 32'h0800);
    repeat (3) begin
      @(negedge clk);
      check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
      check("R8 data stable", {16'd0, out_data}, 32'h0800);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    // second pair was taken into stage 1 during stall; first release drains it
    check("R8 second valid", {31'd0, out_valid}, 32'd1);
    check("R8 second data", {16'd0, out_data}, 32'h0000E000);
    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);

    // R1: reset mid-flight clears the pipeline
    @(negedge clk);
    op_a = 16'h8000; op_b = 16'h8000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 midflight valid", {31'd0, out_valid}, 32'd0);
    check("R1 midflight ovf", {31'd0, out_ovf}, 32'd0);
    @(negedge clk);
    check("R1 flushed", {31'd0, out_valid}, 32'd0);

    finish_run();
  end

endmodule